// File: doc/BRIEF.md
# Register-Mapped Integer Square Root

This unit computes the unsigned floor square root of a radicand held in a 64-bit parameter register. Software, or another block on the same register port, loads the radicand as two 32-bit words. It picks either a 32-bit or a 64-bit operand width with a mode bit in the control register, then polls a busy flag until the 32-bit root can be read from the result register.

The root is built with the digit-by-digit method that uses powers of four. A trial bit walks down two places per clock. Each clock, the running remainder is compared against the partial root plus the trial bit, and the partial root is halved or halved-and-bumped. The leading iterations, where the trial bit still exceeds the radicand, run anyway and leave the root at zero, so the latency depends only on the selected width.

Any write to the control register or to either parameter word starts a computation at once. A write while a computation is running restarts it from the newly written values.

Top module: `isqrt_mmio`

## Requirements
- R1: After reset, the control word (address 0) reads 0, the result word (address 3) reads 0, and the busy flag is clear.
- R2: With control bit 0 at 0, only parameter bits 31:0 form the radicand. The high parameter word (address 2) has no effect on the root.
- R3: With control bit 0 at 1, all 64 parameter bits form the radicand.
- R4: When a computation completes, the result word r satisfies r*r <= x < (r+1)*(r+1), where x is the radicand.
- R5: Control bit 15 (busy) is set from the clock edge that takes a write to address 0, 1 or 2. It then stays set for exactly 16 clock cycles in 32-bit mode and 32 cycles in 64-bit mode, whatever the radicand.
- R6: A write to address 0, 1 or 2 while busy is set abandons the running computation. The full latency of R5 is counted again from that write, and the root is taken from the newly written values.
- R7: A zero radicand yields a zero result.
- R8: The result word keeps its previous value until the computation completes. Writes to address 3 are ignored and start nothing.
- R9: Reads return, one clock after the address is presented: address 0 gives mode in bit 0 and busy in bit 15 (other bits zero); address 1 gives parameter bits 31:0; address 2 gives parameter bits 63:32; address 3 gives the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 2 | Word address: 0 control, 1 parameter low, 2 parameter high, 3 result |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the address of the previous cycle |

## Verification
The assertions assume a synchronous reset held through the first clock edge. They also assume the address and write strobe are settled at every rising edge, so that a start and the operand it captures always belong to one and the same edge. The bench changes its inputs only on falling edges and holds reset high from time zero. It reaches the restart case only through ordinary writes, so every start seen by the checks comes from a legal register write and never from a half-driven bus.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL     = 2'd0,
    REG_PARAM_LO = 2'd1,
    REG_PARAM_HI = 2'd2,
    REG_RESULT   = 2'd3
  } reg_addr_e;

  localparam int MODE_BIT = 0;
  localparam int BUSY_BIT = 15;
endpackage

// File: rtl/isqrt_step.sv
// One digit step of the power-of-four square root.
module isqrt_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] res_i,
  input  logic [W-1:0] bit_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] res_o
);
  logic [W-1:0] trial;

  always_comb begin
    trial = res_i + bit_i;
    if (rem_i >= trial) begin
      rem_o = rem_i - trial;
      res_o = (res_i >> 1) + bit_i;
    end else begin
      rem_o = rem_i;
      res_o = res_i >> 1;
    end
  end
endmodule

// File: rtl/isqrt_iter_core.sv
// Sequencer: fixed iteration count chosen by operand width.
module isqrt_iter_core #(
  parameter int RAD_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 wide,
  input  logic [RAD_W-1:0]     radicand,
  output logic                 busy,
  output logic                 done,
  output logic [RAD_W/2-1:0]   root
);
  localparam int ROOT_W = RAD_W / 2;
  localparam int HALF   = RAD_W / 2;
  localparam int CNT_W  = $clog2(ROOT_W);
  localparam logic [RAD_W-1:0] BIT_WIDE   = RAD_W'(1) << (RAD_W - 2);
  localparam logic [RAD_W-1:0] BIT_NARROW = RAD_W'(1) << (HALF - 2);
  localparam logic [CNT_W-1:0] CNT_WIDE   = CNT_W'(ROOT_W - 1);
  localparam logic [CNT_W-1:0] CNT_NARROW = CNT_W'(ROOT_W / 2 - 1);

  logic [RAD_W-1:0]  rem_q, res_q, bit_q, opnd_q;
  logic [RAD_W-1:0]  rem_n, res_n;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q, wide_q;
  logic [ROOT_W-1:0] root_q;
  logic [RAD_W-1:0]  opnd_start;

  assign opnd_start = wide ? radicand : {{HALF{1'b0}}, radicand[HALF-1:0]};

  isqrt_step #(.W(RAD_W)) u_step (
    .rem_i(rem_q), .res_i(res_q), .bit_i(bit_q),
    .rem_o(rem_n), .res_o(res_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      res_q  <= '0;
      bit_q  <= '0;
      opnd_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wide_q <= 1'b0;
      root_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        opnd_q <= opnd_start;
        rem_q  <= opnd_start;
        res_q  <= '0;
        bit_q  <= wide ? BIT_WIDE : BIT_NARROW;
        cnt_q  <= wide ? CNT_WIDE : CNT_NARROW;
        wide_q <= wide;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_n;
        res_q <= res_n;
        bit_q <= bit_q >> 2;
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          root_q <= res_n[ROOT_W-1:0];
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign root = root_q;

  // Checks on the iteration state
  logic [RAD_W+1:0] sq_lo, sq_hi;
  always_comb begin
    sq_lo = (RAD_W+2)'(root_q) * (RAD_W+2)'(root_q);
    sq_hi = ((RAD_W+2)'(root_q) + 1'b1) * ((RAD_W+2)'(root_q) + 1'b1);
  end

  assert_floor_R4: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (sq_lo <= (RAD_W+2)'(opnd_q)) && (sq_hi > (RAD_W+2)'(opnd_q)));

  assert_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (done_q && opnd_q == '0) |-> root_q == '0);

  assert_narrow_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !wide) |=> opnd_q[RAD_W-1:HALF] == '0);

  assert_wide_R3: assert property (@(posedge clk) disable iff (rst)
    (start && wide) |=> opnd_q == $past(radicand));

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_q && cnt_q == (wide_q ? CNT_WIDE : CNT_NARROW));

  assert_busy_window_R5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (wide_q ? cnt_q <= CNT_WIDE : cnt_q <= CNT_NARROW));
endmodule

// File: rtl/isqrt_mmio.sv
// Register front end: control, two parameter words, result.
module isqrt_mmio
  import isqrt_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata
);
  localparam int RAD_W  = 2 * BUS_W;
  localparam int ROOT_W = RAD_W / 2;

  logic [RAD_W-1:0]  param_q, param_n;
  logic              mode_q, mode_n;
  logic              start;
  logic              busy, done;
  logic [ROOT_W-1:0] root;
  logic [BUS_W-1:0]  rdata_q, ctrl_word, rd_mux;

  always_comb begin
    param_n = param_q;
    mode_n  = mode_q;
    start   = 1'b0;
    if (wr_en) begin
      case (reg_addr_e'(addr))
        REG_CTRL:     begin mode_n = wdata[MODE_BIT]; start = 1'b1; end
        REG_PARAM_LO: begin param_n[BUS_W-1:0] = wdata; start = 1'b1; end
        REG_PARAM_HI: begin param_n[RAD_W-1:BUS_W] = wdata; start = 1'b1; end
        default:      start = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      param_q <= '0;
      mode_q  <= 1'b0;
    end else begin
      param_q <= param_n;
      mode_q  <= mode_n;
    end
  end

  isqrt_iter_core #(.RAD_W(RAD_W)) u_core (
    .clk(clk), .rst(rst), .start(start), .wide(mode_n),
    .radicand(param_n), .busy(busy), .done(done), .root(root)
  );

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[MODE_BIT] = mode_q;
    ctrl_word[BUSY_BIT] = busy;
    case (reg_addr_e'(addr))
      REG_CTRL:     rd_mux = ctrl_word;
      REG_PARAM_LO: rd_mux = param_q[BUS_W-1:0];
      REG_PARAM_HI: rd_mux = param_q[RAD_W-1:BUS_W];
      default:      rd_mux = BUS_W'(root);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy && root == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(root));

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  assert_result_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_RESULT && !busy) |=> !busy);
endmodule

// File: tb/isqrt_mmio_test.sv
module isqrt_mmio_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  isqrt_mmio uut (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata));

  function automatic logic [31:0] ref_root(input logic [63:0] x);
    logic [31:0] r;
    logic [31:0] t;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      t = r | (32'd1 << i);
      if ({32'd0, t} * {32'd0, t} <= x) r = t;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  // Poll control from the negedge right after the write; count busy cycles
  task automatic count_busy(output int n);
    addr = 2'd0;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (rdata[15]) n++;
      else break;
    end
  endtask

  task automatic run(input string req, input bit mode, input logic [63:0] x);
    int n;
    logic [31:0] d;
    logic [63:0] eff;
    wr(2'd2, x[63:32]);
    wr(2'd1, x[31:0]);
    wr(2'd0, {31'd0, mode});
    count_busy(n);
    check({req, " R5 latency"}, n, mode ? 32 : 16);
    rd(2'd3, d);
    eff = mode ? x : {32'd0, x[31:0]};
    check({req, " R4 root"}, d, ref_root(eff));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd3, d); check("R1 result", d, 0);
    rd(2'd1, d); check("R1 param", d, 0);
  endtask

  task automatic t_narrow;
    run("R2 high ignored", 1'b0, 64'hDEAD_BEEF_0000_0010);
    run("R2 max32", 1'b0, 64'h1234_5678_FFFF_FFFF);
    run("R2 plain", 1'b0, 64'h0000_0000_000F_4240);
    run("R2 nonsquare", 1'b0, 64'hFFFF_FFFF_0000_0003);
  endtask

  task automatic t_wide;
    run("R3 allones", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R3 pow", 1'b1, 64'h4000_0000_0000_0000);
    run("R3 square", 1'b1, 64'hFFFF_FFFE_0000_0001);
    run("R3 below square", 1'b1, 64'hFFFF_FFFE_0000_0000);
    run("R3 mid", 1'b1, 64'h002B_DC54_5E14_D3B1);
  endtask

  task automatic t_zero;
    run("R7 zero narrow", 1'b0, 64'h0);
    run("R7 zero wide", 1'b1, 64'h0);
    run("R7 one", 1'b1, 64'h1);
  endtask

  task automatic t_restart;
    int n;
    logic [31:0] d;
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd1_000_000);
    repeat (5) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 32'd144;
    @(negedge clk);
    wr_en = 1'b0;
    count_busy(n);
    check("R6 restart latency", n, 16);
    rd(2'd3, d);
    check("R6 restart root", d, 12);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    run("R8 setup", 1'b0, 64'd49);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 32'd10_000;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd3;
    @(negedge clk);
    d = rdata;
    check("R8 result held while busy", d, 7);
    repeat (20) @(negedge clk);
    rd(2'd3, d);
    check("R8 new result", d, 100);
    wr(2'd3, 32'h5555_5555);
    rd(2'd0, d);
    check("R8 result write starts nothing", d[15], 0);
    rd(2'd3, d);
    check("R8 result write ignored", d, 100);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(2'd2, 32'hA5A5_0F0F);
    wr(2'd1, 32'h1357_9BDF);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R9 param lo", d, 32'h1357_9BDF);
    rd(2'd2, d); check("R9 param hi", d, 32'hA5A5_0F0F);
    repeat (40) @(negedge clk);
    rd(2'd0, d); check("R9 ctrl mode only", d, 32'h0000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_narrow();
    t_wide();
    t_zero();
    t_restart();
    t_hold();
    t_readback();
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule